// File: doc/BRIEF.md
# ALU Condition Flag Generator

This combinational block produces the next values of the four arithmetic condition flags of a 16-bit datapath (overflow, negative, zero, carry). The adder sits outside the block. The block takes the two operands, the adder result and the adder's carries out of the byte and word boundaries. It also takes an operation class, a byte/word select and the flags currently held. Every sign, zero and carry test is taken at the width the select picks: bit 7 and the low byte, or bit 15 and the whole word.

The block returns the complete next flag vector. Flags that the operation class leaves alone are passed through unchanged from the current value. It also returns a per-flag update mask, so the flag register can gate its enables, and a result write enable that is dropped only for compare. Subtraction is assumed to be performed as A + ~B + 1, or A + ~B + C for subtract-with-carry. A carry of 1 after a subtraction therefore means that no borrow occurred.

Top module: `aflag_gen`

## Requirements
- R1: When the negative flag is updated, it equals bit 15 of `result` in word mode (`byte_mode`=0) and bit 7 in byte mode (`byte_mode`=1).
- R2: When the zero flag is updated, it is 1 exactly when `result[15:0]` is zero in word mode, or `result[7:0]` is zero in byte mode.
- R3: For classes ADD (0) and ADDC (1), overflow is 1 only when both operands have the same sign and the result's sign differs from it; otherwise it is 0.
- R4: For classes SUB (2), SUBC (3) and CMP (4), overflow is 1 only when the operands' signs differ and the result's sign differs from the sign of `opnd_a`; otherwise it is 0.
- R5: For classes 0 to 4, carry equals `co_word` in word mode and `co_byte` in byte mode.
- R6: For class LOGIC (5), overflow is forced to 0, N and Z are updated, and carry keeps `flags_cur` bit 0.
- R7: For class LOGIC_CZ (6), overflow is forced to 0 and carry equals the inverse of the computed zero flag.
- R8: For class NONE (7), the update mask is 0000 and `flags_nxt` equals `flags_cur`.
- R9: `res_wr` is 0 for CMP and 1 for every other class.
- R10: Flag vectors use the bit order {V,N,Z,C} from bit 3 down to bit 0. The mask is 1111 for classes 0 to 4 and 6, and 1110 for class 5. Every flag whose mask bit is 0 equals its `flags_cur` bit.
- R11: In byte mode, bits 15:8 of `opnd_a`, `opnd_b` and `result`, and `co_word`, have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| byte_mode | input | 1 | 1 selects byte width, 0 word width |
| opc | input | 3 | Operation class 0..7 (ADD, ADDC, SUB, SUBC, CMP, LOGIC, LOGIC_CZ, NONE) |
| opnd_a | input | 16 | First operand (minuend for subtract) |
| opnd_b | input | 16 | Second operand, uninverted |
| result | input | 16 | Adder or logic result |
| co_byte | input | 1 | Adder carry out of bit 7 |
| co_word | input | 1 | Adder carry out of bit 15 |
| flags_cur | input | 4 | Current flags {V,N,Z,C} |
| flags_nxt | output | 4 | Next flags {V,N,Z,C} |
| upd_mask | output | 4 | Per-flag update mask {V,N,Z,C} |
| res_wr | output | 1 | Result write enable |

## Verification
Random operands are passed through a bench-side adder that computes the true add or subtract, so the sign combinations that do and do not overflow both appear at each width. Directed cases cover several boundaries: 0x7FFF+1 and 0x8000-1, which tell a bit-7 sign test from a bit-15 one; results of 0x0100 in byte mode, which tell low-byte zero detection from full-word zero detection; and byte-mode reruns with the upper bytes scrambled. Each class is also run with every current-flag pattern, which separates masked flags that are passed through from flags that are recomputed.

// File: rtl/aflag_pkg.sv
package aflag_pkg;

    typedef enum logic [2:0] {
        OPC_ADD      = 3'd0,
        OPC_ADDC     = 3'd1,
        OPC_SUB      = 3'd2,
        OPC_SUBC     = 3'd3,
        OPC_CMP      = 3'd4,
        OPC_LOGIC    = 3'd5,
        OPC_LOGIC_CZ = 3'd6,
        OPC_NONE     = 3'd7
    } opc_e;

    typedef struct packed {
        logic v;
        logic n;
        logic z;
        logic c;
    } flags_t;

    function automatic logic opc_is_add(input opc_e o);
        return (o == OPC_ADD) || (o == OPC_ADDC);
    endfunction

    function automatic logic opc_is_sub(input opc_e o);
        return (o == OPC_SUB) || (o == OPC_SUBC) || (o == OPC_CMP);
    endfunction

    function automatic logic opc_is_logic(input opc_e o);
        return (o == OPC_LOGIC) || (o == OPC_LOGIC_CZ);
    endfunction

endpackage

// File: rtl/aflag_width_view.sv
module aflag_width_view #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] result,
    input  logic              co_byte,
    input  logic              co_word,
    output logic              sgn_a,
    output logic              sgn_b,
    output logic              sgn_r,
    output logic              is_zero,
    output logic              carry
);
    localparam int MSB_W = DATA_W - 1;
    localparam int MSB_B = BYTE_W - 1;

    logic zero_word;
    logic zero_byte;

    generate
        if (BYTE_W < DATA_W) begin : g_split
            assign zero_byte = (result[MSB_B:0] == '0);
        end else begin : g_same
            assign zero_byte = (result == '0);
        end
    endgenerate

    assign zero_word = (result == '0);

    always_comb begin
        if (byte_mode) begin
            sgn_a   = opnd_a[MSB_B];
            sgn_b   = opnd_b[MSB_B];
            sgn_r   = result[MSB_B];
            is_zero = zero_byte;
            carry   = co_byte;
        end else begin
            sgn_a   = opnd_a[MSB_W];
            sgn_b   = opnd_b[MSB_W];
            sgn_r   = result[MSB_W];
            is_zero = zero_word;
            carry   = co_word;
        end
    end

    // R2: a zero result can never carry a set sign bit
    always_comb begin
        a_r2_zero_no_sign: assert (!(is_zero && sgn_r));
    end

endmodule

// File: rtl/aflag_ovf.sv
module aflag_ovf
    import aflag_pkg::*;
(
    input  opc_e opc,
    input  logic sgn_a,
    input  logic sgn_b,
    input  logic sgn_r,
    output logic ovf
);
    logic ovf_add;
    logic ovf_sub;

    assign ovf_add = (sgn_a == sgn_b) && (sgn_r != sgn_a);
    assign ovf_sub = (sgn_a != sgn_b) && (sgn_r != sgn_a);

    always_comb begin
        if (opc_is_add(opc))      ovf = ovf_add;
        else if (opc_is_sub(opc)) ovf = ovf_sub;
        else                      ovf = 1'b0;
    end

    // R3: an add whose result sign matches operand A never overflows
    always_comb begin
        a_r3_add_same_sign: assert (!(opc_is_add(opc) && sgn_r == sgn_a && ovf));
    end
    // R4: a subtract of operands of equal sign never overflows
    always_comb begin
        a_r4_sub_equal_sign: assert (!(opc_is_sub(opc) && sgn_a == sgn_b && ovf));
    end

endmodule

// File: rtl/aflag_mask.sv
module aflag_mask
    import aflag_pkg::*;
(
    input  opc_e   opc,
    output flags_t mask,
    output logic   res_wr
);
    always_comb begin
        unique case (opc)
            OPC_LOGIC: mask = '{v: 1'b1, n: 1'b1, z: 1'b1, c: 1'b0};
            OPC_NONE:  mask = '{v: 1'b0, n: 1'b0, z: 1'b0, c: 1'b0};
            default:   mask = '{v: 1'b1, n: 1'b1, z: 1'b1, c: 1'b1};
        endcase
        res_wr = (opc != OPC_CMP);
    end

endmodule

// File: rtl/aflag_gen.sv
module aflag_gen
    import aflag_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              byte_mode,
    input  logic [2:0]        opc,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] result,
    input  logic              co_byte,
    input  logic              co_word,
    input  logic [3:0]        flags_cur,
    output logic [3:0]        flags_nxt,
    output logic [3:0]        upd_mask,
    output logic              res_wr
);
    localparam int NFLAG = 4;

    opc_e   opc_q;
    flags_t cur;
    flags_t calc;
    flags_t mask;
    flags_t nxt;
    logic   sgn_a, sgn_b, sgn_r, is_zero, carry, ovf;

    assign opc_q = opc_e'(opc);
    assign cur   = flags_t'(flags_cur);

    aflag_width_view #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_view (
        .byte_mode (byte_mode),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .result    (result),
        .co_byte   (co_byte),
        .co_word   (co_word),
        .sgn_a     (sgn_a),
        .sgn_b     (sgn_b),
        .sgn_r     (sgn_r),
        .is_zero   (is_zero),
        .carry     (carry)
    );

    aflag_ovf u_ovf (
        .opc   (opc_q),
        .sgn_a (sgn_a),
        .sgn_b (sgn_b),
        .sgn_r (sgn_r),
        .ovf   (ovf)
    );

    aflag_mask u_mask (
        .opc    (opc_q),
        .mask   (mask),
        .res_wr (res_wr)
    );

    always_comb begin
        calc.v = ovf;
        calc.n = sgn_r;
        calc.z = is_zero;
        calc.c = (opc_q == OPC_LOGIC_CZ) ? ~is_zero : carry;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NFLAG; gi++) begin : g_sel
            assign nxt[gi] = mask[gi] ? calc[gi] : cur[gi];
        end
    endgenerate

    assign flags_nxt = nxt;
    assign upd_mask  = mask;

    // R10: flags outside the mask pass through unchanged
    always_comb begin
        a_r10_hold_masked: assert (((nxt ^ cur) & ~mask) == '0);
    end
    // R6, R7: logical classes never report overflow
    always_comb begin
        a_r6_logic_no_ovf: assert (!(opc_is_logic(opc_q) && nxt.v));
    end
    // R7: carry is the complement of zero for the inverted-zero class
    always_comb begin
        a_r7_carry_not_zero: assert (!(opc_q == OPC_LOGIC_CZ && nxt.c == nxt.z));
    end
    // R8: the no-update class leaves every flag alone
    always_comb begin
        a_r8_none_holds: assert (!(opc_q == OPC_NONE && nxt != cur));
    end

endmodule

// File: tb/tb_aflag_gen.sv
module tb_aflag_gen;

    logic        clk = 1'b0;
    logic        byte_mode;
    logic [2:0]  opc;
    logic [15:0] opnd_a, opnd_b, result;
    logic        co_byte, co_word;
    logic [3:0]  flags_cur, flags_nxt, upd_mask;
    logic        res_wr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;  // 250 MHz

    aflag_gen dut (
        .byte_mode (byte_mode),
        .opc       (opc),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .result    (result),
        .co_byte   (co_byte),
        .co_word   (co_word),
        .flags_cur (flags_cur),
        .flags_nxt (flags_nxt),
        .upd_mask  (upd_mask),
        .res_wr    (res_wr)
    );

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b (opc=%0d byte=%0b a=%h b=%h r=%h cur=%b)",
                     req, got, exp, opc, byte_mode, opnd_a, opnd_b, result, flags_cur);
        end
    endtask

    // Drives a true add or subtract result for the operands and class.
    task automatic drive_arith(input logic bm, input logic [2:0] oc, input logic [15:0] a,
                               input logic [15:0] b, input logic [3:0] cur);
        logic [16:0] s;
        logic [8:0]  sl;
        logic        cin;
        logic [15:0] bb;
        cin = 1'b0;
        bb  = b;
        if (oc == 3'd1) cin = cur[0];
        if (oc == 3'd2 || oc == 3'd4) begin bb = ~b; cin = 1'b1; end
        if (oc == 3'd3) begin bb = ~b; cin = cur[0]; end
        s  = {1'b0, a} + {1'b0, bb} + {16'd0, cin};
        sl = {1'b0, a[7:0]} + {1'b0, bb[7:0]} + {8'd0, cin};
        byte_mode = bm; opc = oc; opnd_a = a; opnd_b = b;
        result = s[15:0]; co_word = s[16]; co_byte = sl[8]; flags_cur = cur;
    endtask

    task automatic verify();
        logic sa, sb, sr, z, c, v;
        logic [3:0] calc, m, exp;
        @(negedge clk);
        sa = byte_mode ? opnd_a[7] : opnd_a[15];
        sb = byte_mode ? opnd_b[7] : opnd_b[15];
        sr = byte_mode ? result[7] : result[15];
        z  = byte_mode ? (result[7:0] == 8'd0) : (result == 16'd0);
        c  = byte_mode ? co_byte : co_word;
        v  = 1'b0;
        if (opc <= 3'd1) v = (sa == sb) && (sr != sa);
        else if (opc <= 3'd4) v = (sa != sb) && (sr != sa);
        if (opc == 3'd6) c = ~z;
        calc = {v, sr, z, c};
        m = (opc == 3'd7) ? 4'b0000 : (opc == 3'd5) ? 4'b1110 : 4'b1111;
        exp = (calc & m) | (flags_cur & ~m);
        check("R1 N",  {3'b0, flags_nxt[2]}, {3'b0, exp[2]});
        check("R2 Z",  {3'b0, flags_nxt[1]}, {3'b0, exp[1]});
        check(opc <= 3'd1 ? "R3 V" : opc <= 3'd4 ? "R4 V" : "R6/R7 V",
              {3'b0, flags_nxt[3]}, {3'b0, exp[3]});
        check(opc == 3'd5 ? "R6 C" : opc == 3'd6 ? "R7 C" : "R5 C",
              {3'b0, flags_nxt[0]}, {3'b0, exp[0]});
        check(opc == 3'd7 ? "R8 mask" : "R10 mask", upd_mask, m);
        check("R9 res_wr", {3'b0, res_wr}, {3'b0, opc != 3'd4});
    endtask

    task automatic drive_logic(input logic bm, input logic [2:0] oc, input logic [15:0] r,
                               input logic [3:0] cur);
        byte_mode = bm; opc = oc; opnd_a = r ^ 16'h5a5a; opnd_b = 16'h5a5a;
        result = r; co_byte = 1'b1; co_word = 1'b1; flags_cur = cur;
    endtask

    initial begin
        process::self().srandom(32'd12345);
        drive_logic(1'b0, 3'd7, 16'h0000, 4'b0000);
        // reset-state style idle check: NONE class with cleared flags
        verify();
        // R1 directed: 0x7FFF+1 word sets N; byte sees 0x00 (Z, no N)
        drive_arith(1'b0, 3'd0, 16'h7fff, 16'h0001, 4'b0000); verify();
        check("R3 word overflow", flags_nxt, 4'b1100);
        drive_arith(1'b1, 3'd0, 16'h7fff, 16'h0001, 4'b0000); verify();
        check("R5 byte carry", flags_nxt, 4'b0011);
        // R4 directed: 0x8000-1 word overflows
        drive_arith(1'b0, 3'd2, 16'h8000, 16'h0001, 4'b0000); verify();
        check("R4 word sub overflow", flags_nxt, 4'b1001);
        // R2 directed: byte zero with upper byte set
        drive_logic(1'b1, 3'd5, 16'h0100, 4'b0001); verify();
        check("R2 byte zero", flags_nxt, 4'b0011);
        drive_logic(1'b0, 3'd6, 16'h0100, 4'b0000); verify();
        check("R7 word nonzero", flags_nxt, 4'b0001);
        drive_logic(1'b1, 3'd6, 16'hff00, 4'b1111); verify();
        check("R7 byte zero", flags_nxt, 4'b0010);
        // R9 compare
        drive_arith(1'b0, 3'd4, 16'h1234, 16'h1234, 4'b0000); verify();
        check("R9 cmp equal", {flags_nxt, 3'b0, res_wr}, {4'b0011, 4'b0000});
        // every class with every current-flag pattern (R8, R10)
        for (int oc = 0; oc < 8; oc++) begin
            for (int cf = 0; cf < 16; cf++) begin
                drive_arith(1'b0, oc[2:0], 16'h4000, 16'h4000, cf[3:0]);
                if (oc >= 5) drive_logic(1'b0, oc[2:0], 16'h4000, cf[3:0]);
                verify();
            end
        end
        // random traffic plus R11 byte-mode upper-bits check
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a, b;
            logic [2:0]  oc;
            logic [3:0]  cf;
            logic        bm;
            logic [3:0]  ref_f, ref_m;
            logic        ref_w;
            a = 16'($urandom); b = 16'($urandom); oc = 3'($urandom);
            cf = 4'($urandom); bm = 1'($urandom);
            if (($urandom % 4) == 0) b = a;
            if (oc >= 3'd5) drive_logic(bm, oc, a & b, cf);
            else drive_arith(bm, oc, a, b, cf);
            verify();
            if (bm) begin
                ref_f = flags_nxt; ref_m = upd_mask; ref_w = res_wr;
                opnd_a[15:8] = 8'($urandom); opnd_b[15:8] = 8'($urandom);
                result[15:8] = 8'($urandom); co_word = ~co_word;
                @(negedge clk);
                check("R11 upper bits flags", flags_nxt, ref_f);
                check("R11 upper bits mask", {upd_mask[3:1], res_wr}, {ref_m[3:1], ref_w});
            end
        end
        done = 1;
    end

    initial begin
        for (int t = 0; t < 150000; t++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule